// File: doc/BRIEF.md
# Subcarrier Phase Generator with Serial Frequency Lock

This block produces the running phase of a colour subcarrier by means of a phase accumulator. It adds a frequency word to a wide phase register on every clock and lets the sum wrap. Software sets the frequency word through a small byte-wide write port. The word is the subcarrier periods per video line divided by the pixel clocks per line, times two to the accumulator width, rounded to the nearest integer. The reset value is the NTSC word 0x21F07C1F: 227.5 periods over 1716 clocks.

In lock mode an upstream decoder steers the phase over a one-wire serial stream. Each frame carries a 22-bit increment, a line-sequence flag and an accumulator reset flag. The block forms its frequency word from the streamed increment in the upper bits and the low bits of the local registers. It can clear the phase on command. When the PAL standard is selected it reports the line-inversion flag. The phase output drives a sine lookup further down the chain.

Top module: `sc_dds_lock`

## Requirements
- R1: After reset the phase output is 0, the line-inversion flag is 0, and the frequency word is 0x21F07C1F.
- R2: A write with `wr_en` high stores `wr_data` into byte `wr_addr` of the frequency word. Address 0 is bits 7:0 and address 3 is bits 31:24. The add at the write edge still uses the old word, and the add at the following edge uses the new one.
- R3: In register mode (`lock_mode`=0) the phase grows by the register word at every rising clock edge, modulo 2^32.
- R4: Capture starts at an edge where `lock_ser` is sampled 0 while it was 1 at the previous edge and no frame is in progress. The following 24 edges each sample one bit in this order: the increment, most significant bit first (22 bits), then the sequence bit, then the reset bit.
- R5: In lock mode the frequency word is the last received increment in bits 31:10 and register bits 9:0 in bits 9:0. The held increment is 0 after reset.
- R6: A received increment first affects the add at the edge after the one that samples the reset bit. The add at that completion edge still uses the previous increment.
- R7: In lock mode a frame whose reset bit is 1 sets the phase to 0 at the completion edge instead of adding. From the next edge the phase again grows by the active word.
- R8: In register mode the reset bit of a frame is ignored, and the held increment has no effect on the phase.
- R9: `line_inv` is 1 exactly when `pal_mode`=1, `lock_mode`=1 and the sequence bit of the last complete frame was 1. With `pal_mode`=0 (NTSC) it stays 0.
- R10: Falling transitions on `lock_ser` while a frame is being captured do not restart capture and do not corrupt the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe for the frequency word |
| wr_addr | input | 2 | Byte index, 0 = least significant |
| wr_data | input | 8 | Byte to store |
| lock_mode | input | 1 | 0 = register word, 1 = serial-lock word |
| pal_mode | input | 1 | 1 = PAL line alternation reported |
| lock_ser | input | 1 | Serial lock stream, idle high |
| phase | output | 32 | Accumulator phase |
| line_inv | output | 1 | PAL inverted-line flag |

## Verification
The assertions assume that `lock_ser` is already synchronous to `clk`, that `wr_addr` never exceeds 3, and that the mode inputs change only between edges. The stimulus drives every input just after the falling clock edge. It draws addresses only in the range 0 to 3, and it toggles `lock_ser` either as well-formed frames or as random bits, so mid-frame falls and back-to-back frames both occur. A bench reference model, driven only by the input values seen at each edge, predicts the phase and flag. Directed frames test wrap-around, clearing, delayed take-effect and the ignored reset bit.

// File: rtl/sc_dds_pkg.sv
package sc_dds_pkg;

   localparam int unsigned DEF_ACC_W  = 32;
   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_INC_W  = 22;
   localparam logic [31:0] NTSC_WORD  = 32'h21F0_7C1F;

   typedef enum logic {
      SRC_REGS = 1'b0,
      SRC_LOCK = 1'b1
   } word_src_e;

   typedef struct packed {
      logic seq_bit;
      logic rst_bit;
   } frame_flags_t;

endpackage

// File: rtl/sc_dds_regbank.sv
module sc_dds_regbank #(
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned BYTE_W     = 8,
   parameter logic [ACC_W-1:0] RESET_WORD = '0,
   localparam int unsigned NBYTES    = ACC_W / BYTE_W,
   localparam int unsigned AW        = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [ACC_W-1:0]  word_o
);

   generate
      if (ACC_W % BYTE_W != 0) begin : g_bad_split
         $error("sc_dds_regbank: ACC_W must be a multiple of BYTE_W");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NBYTES; gi++) begin : g_lane
         logic [BYTE_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= RESET_WORD[gi*BYTE_W +: BYTE_W];
            end else if (wr_en && (wr_addr == AW'(gi))) begin
               lane_q <= wr_data;
            end
         end
         assign word_o[gi*BYTE_W +: BYTE_W] = lane_q;
      end
   endgenerate

   // R2: a write lands in the addressed byte at the next edge
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (word_o[$past(wr_addr)*BYTE_W +: BYTE_W] == $past(wr_data)));

endmodule

// File: rtl/sc_dds_lockrx.sv
module sc_dds_lockrx #(
   parameter int unsigned INC_W     = 22,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned FRAME_BITS = INC_W + 2,
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_i,
   output logic             done_o,
   output logic [INC_W-1:0] inc_o,
   output logic             seq_o,
   output logic             rst_o
);

   generate
      if (INC_W < 1) begin : g_bad_inc
         $error("sc_dds_lockrx: INC_W must be at least 1");
      end
   endgenerate

   logic             ser_q;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [INC_W:0]   sh_q;
   logic             start;
   logic             last;

   assign start = !busy_q && ser_q && !ser_i;
   assign last  = busy_q && (cnt_q == CNT_W'(FRAME_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_q  <= 1'b0;
         busy_q <= 1'b0;
         cnt_q  <= '0;
         sh_q   <= '0;
      end else begin
         ser_q <= ser_i;
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            sh_q  <= {sh_q[INC_W-1:0], ser_i};
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign done_o = last;
   assign seq_o  = sh_q[0];
   assign rst_o  = ser_i;

   genvar gb;
   generate
      if (MSB_FIRST) begin : g_msb
         assign inc_o = sh_q[INC_W:1];
      end else begin : g_lsb
         for (gb = 0; gb < INC_W; gb++) begin : g_rev
            assign inc_o[gb] = sh_q[INC_W - gb];
         end
      end
   endgenerate

   // R4: bit counter never passes the frame length
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q < CNT_W'(FRAME_BITS)));

   // R4: capture only opens after a sampled high-to-low step
   p_start_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> ($past(ser_q) && !$past(ser_i)));

   // R10: a frame in progress is never cut short
   p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> (busy_q && (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/sc_dds_phase_acc.sv
module sc_dds_phase_acc #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] step_i,
   input  logic             clear_i,
   output logic [ACC_W-1:0] phase_o
);

   generate
      if (ACC_W < 2) begin : g_bad_acc
         $error("sc_dds_phase_acc: ACC_W must be at least 2");
      end
   endgenerate

   logic [ACC_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (clear_i) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + step_i;
      end
   end

   assign phase_o = phase_q;

   // R7: a clear request leaves the phase at zero
   p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (phase_o == '0));

endmodule

// File: rtl/sc_dds_lock.sv
module sc_dds_lock
   import sc_dds_pkg::*;
#(
   parameter int unsigned ACC_W      = DEF_ACC_W,
   parameter int unsigned BYTE_W     = DEF_BYTE_W,
   parameter int unsigned INC_W      = DEF_INC_W,
   parameter logic [ACC_W-1:0] RESET_WORD = ACC_W'(NTSC_WORD),
   parameter bit          MSB_FIRST  = 1'b1,
   localparam int unsigned LOW_W     = ACC_W - INC_W,
   localparam int unsigned NBYTES    = ACC_W / BYTE_W,
   localparam int unsigned AW        = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              lock_mode,
   input  logic              pal_mode,
   input  logic              lock_ser,
   output logic [ACC_W-1:0]  phase,
   output logic              line_inv
);

   generate
      if (INC_W >= ACC_W) begin : g_bad_merge
         $error("sc_dds_lock: INC_W must be narrower than ACC_W");
      end
   endgenerate

   logic [ACC_W-1:0] reg_word;
   logic [ACC_W-1:0] lock_word;
   logic [ACC_W-1:0] act_word;
   logic             rx_done;
   logic [INC_W-1:0] rx_inc;
   frame_flags_t     rx_flags;
   logic [INC_W-1:0] held_inc_q;
   logic             seq_q;
   logic             acc_clear;
   word_src_e        src;

   sc_dds_regbank #(
      .ACC_W      (ACC_W),
      .BYTE_W     (BYTE_W),
      .RESET_WORD (RESET_WORD)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .word_o  (reg_word)
   );

   sc_dds_lockrx #(
      .INC_W     (INC_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ser_i  (lock_ser),
      .done_o (rx_done),
      .inc_o  (rx_inc),
      .seq_o  (rx_flags.seq_bit),
      .rst_o  (rx_flags.rst_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_inc_q <= '0;
         seq_q      <= 1'b0;
      end else if (rx_done) begin
         held_inc_q <= rx_inc;
         seq_q      <= rx_flags.seq_bit;
      end
   end

   assign src       = lock_mode ? SRC_LOCK : SRC_REGS;
   assign lock_word = {held_inc_q, reg_word[LOW_W-1:0]};

   always_comb begin
      unique case (src)
         SRC_LOCK: act_word = lock_word;
         default:  act_word = reg_word;
      endcase
   end

   assign acc_clear = rx_done && rx_flags.rst_bit && (src == SRC_LOCK);

   sc_dds_phase_acc #(
      .ACC_W (ACC_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (act_word),
      .clear_i (acc_clear),
      .phase_o (phase)
   );

   assign line_inv = pal_mode && (src == SRC_LOCK) && seq_q;

   // R6: held increment only moves when a frame completes
   p_hold_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |=> $stable(held_inc_q));

   // R9: NTSC never reports an inverted line
   p_ntsc_flat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pal_mode |-> !line_inv);

   // R8: in register mode a completing frame still just adds the register word
   p_regmode_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_mode && rx_done) |=> (phase == $past(phase) + $past(reg_word)));

endmodule

// File: tb/tb_sc_dds_lock.sv
`timescale 1ns/1ps
module tb_sc_dds_lock;

   localparam int FB = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        lock_mode = 1'b0;
   logic        pal_mode = 1'b0;
   logic        lock_ser = 1'b1;
   logic [31:0] phase;
   logic        line_inv;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference model state
   logic [31:0] m_word, m_phase;
   logic [21:0] m_inc;
   logic        m_seq, m_prev, m_busy;
   int          m_cnt;
   logic [22:0] m_bits;

   always #2 clk = ~clk;

   sc_dds_lock dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .lock_mode(lock_mode), .pal_mode(pal_mode),
      .lock_ser(lock_ser), .phase(phase), .line_inv(line_inv)
   );

   function automatic logic [31:0] sel_word(logic lk, logic [31:0] w, logic [21:0] inc);
      return lk ? {inc, w[9:0]} : w;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_word = 32'h21F07C1F; m_phase = '0; m_inc = '0; m_seq = 1'b0;
      m_prev = 1'b0; m_busy = 1'b0; m_cnt = 0; m_bits = '0;
   endtask

   task automatic model_edge();
      logic done, start;
      logic [31:0] w;
      w     = sel_word(lock_mode, m_word, m_inc);
      done  = m_busy && (m_cnt == FB - 1);
      start = !m_busy && m_prev && !lock_ser;
      if (done && lock_ser && lock_mode) m_phase = '0;
      else                               m_phase = m_phase + w;
      if (wr_en) m_word[wr_addr*8 +: 8] = wr_data;
      if (start) begin
         m_busy = 1'b1; m_cnt = 0;
      end else if (m_busy) begin
         if (done) begin
            m_inc = m_bits[22:1]; m_seq = m_bits[0]; m_busy = 1'b0;
         end
         m_bits = {m_bits[21:0], lock_ser};
         m_cnt++;
      end
      m_prev = lock_ser;
   endtask

   // one clock: model follows the edge, outputs compared after the falling edge
   task automatic step(input string req);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(phase == m_phase, req, phase, m_phase);
      check(line_inv == (pal_mode && lock_mode && m_seq), {req, " R9"},
            {31'd0, line_inv}, {31'd0, pal_mode && lock_mode && m_seq});
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step("R2");
      wr_en = 1'b0;
   endtask

   task automatic send_frame(input logic [21:0] inc, input logic seq, input logic rs, input string req);
      lock_ser = 1'b1; step(req);
      lock_ser = 1'b0; step(req);
      for (int i = 21; i >= 0; i--) begin
         lock_ser = inc[i]; step(req);
      end
      lock_ser = seq; step(req);
      lock_ser = rs;  step(req);
      lock_ser = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] p0, p1, w0;
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      check(phase == 32'd0, "R1 phase", phase, 32'd0);
      check(line_inv == 1'b0, "R1 line_inv", {31'd0, line_inv}, 32'd0);
      rst_n = 1'b1;
      // R1/R3: default NTSC word per clock
      p0 = phase; step("R3"); p1 = phase;
      check(p1 - p0 == 32'h21F07C1F, "R1 default word", p1 - p0, 32'h21F07C1F);
      // R2: byte order and write timing
      p0 = phase; wr(2'd3, 8'h44); p1 = phase;
      check(p1 - p0 == 32'h21F07C1F, "R2 old word at write edge", p1 - p0, 32'h21F07C1F);
      p0 = phase; step("R2"); p1 = phase;
      check(p1 - p0 == 32'h44F07C1F, "R2 msb byte", p1 - p0, 32'h44F07C1F);
      wr(2'd0, 8'h01); p0 = phase; step("R2"); p1 = phase;
      check(p1 - p0 == 32'h44F07C01, "R2 lsb byte", p1 - p0, 32'h44F07C01);
      // R3: wrap modulo 2^32 with all-ones word
      for (int b = 0; b < 4; b++) wr(b[1:0], 8'hFF);
      p0 = phase; step("R3"); p1 = phase;
      check(p1 == p0 - 32'd1, "R3 wrap", p1, p0 - 32'd1);
      wr(2'd0, 8'h2B); wr(2'd1, 8'h01); // low ten bits = 0x12B
      // R5/R6/R9/R10: lock frame, alternating bits, PAL
      lock_mode = 1'b1; pal_mode = 1'b1;
      send_frame(22'h2AAAAA, 1'b1, 1'b0, "R10");
      // last step was completion edge; next add uses the new word
      w0 = {22'h2AAAAA, 10'h12B};
      p0 = phase; step("R6"); p1 = phase;
      check(p1 - p0 == w0, "R5 merged word", p1 - p0, w0);
      check(line_inv == 1'b1, "R9 pal inverted", {31'd0, line_inv}, 32'd1);
      pal_mode = 1'b0; step("R9");
      check(line_inv == 1'b0, "R9 ntsc flat", {31'd0, line_inv}, 32'd0);
      // R6: completion edge still uses the old increment
      lock_ser = 1'b1; step("R6");
      lock_ser = 1'b0; step("R6");
      for (int i = 21; i >= 0; i--) begin lock_ser = 1'(22'h0F0F0F >> i); step("R6"); end
      lock_ser = 1'b0; step("R6");
      lock_ser = 1'b0; p0 = phase; step("R6"); p1 = phase;
      check(p1 - p0 == w0, "R6 old word at completion", p1 - p0, w0);
      lock_ser = 1'b1; p0 = phase; step("R6"); p1 = phase;
      check(p1 - p0 == {22'h0F0F0F, 10'h12B}, "R6 new word after", p1 - p0, {22'h0F0F0F, 10'h12B});
      // R7: reset bit in lock mode clears phase
      send_frame(22'h123456, 1'b0, 1'b1, "R7");
      check(phase == 32'd0, "R7 cleared", phase, 32'd0);
      step("R7");
      check(phase == {22'h123456, 10'h12B}, "R7 resumes", phase, {22'h123456, 10'h12B});
      // R8: register mode ignores reset bit and held increment
      lock_mode = 1'b0;
      send_frame(22'h3FFFFF, 1'b1, 1'b1, "R8");
      check(phase != 32'd0, "R8 not cleared", phase, 32'd1);
      p0 = phase; step("R8"); p1 = phase;
      check(p1 - p0 == m_word, "R8 reg word", p1 - p0, m_word);
      // random mix
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 8) wr(2'($urandom_range(0, 3)), 8'($urandom));
         else if (r < 10) lock_mode = ~lock_mode;
         else if (r < 12) pal_mode = ~pal_mode;
         else if (r < 15) send_frame(22'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0), "R4");
         else begin
            lock_ser = (r < 60) ? 1'($urandom) : 1'b1;
            step("R3");
         end
      end
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule